// File: doc/BRIEF.md
# Flash Command and Interrupt Status Unit

This block holds the command, configuration and status registers of a flash controller. Software reaches it through a 16-bit register port. Each write or read picks one register with a 3-bit select. When software writes a command, the block sorts it into an operation class. For array operations (load, program, erase), the block emits a one-cycle execute strobe to the array sequencer. The sequencer reports back through an operation-done input and a failure input.

Completion and failure are recorded as bits in an interrupt-status register and a controller-status register. Software acknowledges by write-AND into the interrupt register. While the global interrupt bit is set, new commands are refused. The block drives a registered interrupt pin whose polarity comes from configuration register 1, and a ready pin that follows a bit of the same register.

Top module: `flash_csr_unit`

## Requirements
- R1: After cold reset, the registers read as follows: configuration 1 = 0x40c0, configuration 2 = 0x0000, status = 0x0000, interrupt = 0x8080, command = 0x0000. The ready pin is 1 and the interrupt pin is 1.
- R2: Select codes are 0 command, 1 configuration 1, 2 configuration 2, 3 controller status and 4 interrupt status.
  - Configuration 1 reads back as its value ANDed with 0xffe0. Configuration 2 reads back as written.
  - Writes to status, and any access to codes 5 to 7, have no effect. Codes 5 to 7 read as 0.
- R3: A command write is refused while interrupt bit 15 is 1. The command register keeps its value and no execute strobe is produced.
- R4: On each clock, the interrupt pin takes interrupt bit 15 XOR the inverse of configuration-1 bit 6, using the values held before that clock.
- R5: A configuration-1 write copies written bit 7 to the ready pin on the same clock. Any reset sets the ready pin to 1.
- R6: An accepted command is stored and reads back. For array opcodes, the execute strobe is high for exactly the clock cycle after the write, with the following operation class:
  - class 1: load opcodes 0x0000 and 0x0013;
  - class 2: program opcodes 0x0080, 0x001a and 0x001b;
  - class 3: erase opcodes 0x0094, 0x0095 and 0x0030.
- R7: An operation-done pulse for a pending array command sets interrupt bit 15 plus the class bit: 7 for load, 6 for program, 5 for erase. A done pulse with nothing pending has no effect.
- R8: Done together with failure also sets status bit 10 and the class error bit: 13 for load, 12 for program, 11 for erase.
- R9: The remaining command values are handled as follows:
  - opcodes 0x0023, 0x0027, 0x002a, 0x002c, 0x0071 and 0x0065 set only interrupt bit 15;
  - 0x00b0 sets nothing;
  - every other value sets status bit 10 and interrupt bit 15.
- R10: A write to the interrupt register ANDs the data into it. If bit 15 of the result is 0, status bits 13 to 10 are cleared.
- R11: An accepted 0x00f0 or 0x00f3 puts the block in the following state:
  - configuration registers at their reset values;
  - status 0, interrupt 0x8010, command 0 and ready 1;
  - any pending array command dropped.
- R12: When an interrupt write and a completion occur in the same clock, the write-AND applies first and the completion bits are then ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Cold reset, active low, asynchronous |
| wrEn | input | 1 | Register write enable |
| regSel | input | 3 | Register select |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the selected register |
| opDone | input | 1 | Array operation finished |
| opFail | input | 1 | Finished operation failed (valid with opDone) |
| execStrobe | output | 1 | One-cycle start of an array operation |
| opClass | output | 2 | Class of the started operation (1 load, 2 program, 3 erase) |
| intPin | output | 1 | Interrupt pin, registered |
| readyPin | output | 1 | Ready pin |

## Verification
The hardest cases to reach are the races: a completion arriving in the same clock as an acknowledge write, and a warm reset issued while an array command is still pending. The bench reaches both from the ports.

- For the race with the acknowledge write, it clears the interrupt register, starts a load, and then drives the write-AND and the done pulse together.
- For the warm reset case, it starts a resume, issues 0x00f3 before the done pulse, and then sends the late done pulse.

In both cases, a behavioural reference model compares every output on every clock.

// File: rtl/flash_csr_pkg.sv
package flash_csr_pkg;

  localparam int REG_W = 16;
  localparam int SEL_W = 3;
  localparam int CLS_W = 2;

  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CFG1 = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CFG2 = 3'd2;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_INT  = 3'd4;

  localparam logic [REG_W-1:0] CFG1_RST     = 16'h40c0;
  localparam logic [REG_W-1:0] CFG2_RST     = 16'h0000;
  localparam logic [REG_W-1:0] INT_COLD     = 16'h8080;
  localparam logic [REG_W-1:0] INT_WARM     = 16'h8010;
  localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hffe0;

  localparam int INT_ANY   = 15;
  localparam int INT_DONE0 = 5;   // erase, program, load occupy 5..7
  localparam int ERR_CMD   = 10;
  localparam int ERR_KIND0 = 11;  // erase, program, load occupy 11..13
  localparam int CFG1_POL  = 6;
  localparam int CFG1_RDY  = 7;

  typedef enum logic [2:0] {
    OPK_LOAD, OPK_PROG, OPK_ERASE, OPK_INSTANT, OPK_HOLD, OPK_RESTART, OPK_BAD
  } opKind_e;

  // one-hot kind vectors: bit2 load, bit1 program, bit0 erase
  typedef struct packed {
    logic       warmRst;
    logic       cmdTake;
    logic       raiseInt;
    logic [2:0] doneKind;
    logic       cmdErr;
    logic [2:0] failKind;
  } ctrlStrobe_t;

  function automatic opKind_e classifyOp(input logic [REG_W-1:0] v);
    opKind_e k;
    case (v)
      16'h0000, 16'h0013:                     k = OPK_LOAD;
      16'h0080, 16'h001a, 16'h001b:           k = OPK_PROG;
      16'h0094, 16'h0095, 16'h0030:           k = OPK_ERASE;
      16'h0023, 16'h0027, 16'h002a, 16'h002c,
      16'h0071, 16'h0065:                     k = OPK_INSTANT;
      16'h00b0:                               k = OPK_HOLD;
      16'h00f0, 16'h00f3:                     k = OPK_RESTART;
      default:                                k = OPK_BAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/flash_csr_ctrl.sv
module flash_csr_ctrl
  import flash_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [REG_W-1:0] wrData,
  input  logic             intBusy,
  input  logic             opDone,
  input  logic             opFail,
  output ctrlStrobe_t      stb,
  output logic             execStrobe,
  output logic [CLS_W-1:0] opClass
);

  localparam logic [CLS_W-1:0] CLS_NONE = '0;

  opKind_e          kind;
  logic             accept;
  logic             armArray;
  logic [CLS_W-1:0] armCode;
  logic [CLS_W-1:0] pendQ;
  logic             finish;
  logic [2:0]       pendHot;

  assign kind   = classifyOp(wrData);
  assign accept = cmdWr && !intBusy;

  always_comb begin
    armCode = CLS_NONE;
    case (kind)
      OPK_LOAD:  armCode = 2'd1;
      OPK_PROG:  armCode = 2'd2;
      OPK_ERASE: armCode = 2'd3;
      default:   armCode = CLS_NONE;
    endcase
  end

  assign armArray = accept && (armCode != CLS_NONE);
  assign finish   = opDone && (pendQ != CLS_NONE);

  // pending class to one-hot {load, program, erase}
  always_comb begin
    pendHot = 3'b000;
    case (pendQ)
      2'd1:    pendHot = 3'b100;
      2'd2:    pendHot = 3'b010;
      2'd3:    pendHot = 3'b001;
      default: pendHot = 3'b000;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.cmdTake = accept;
    stb.warmRst = accept && (kind == OPK_RESTART);
    if (accept && kind == OPK_INSTANT) stb.raiseInt = 1'b1;
    if (accept && kind == OPK_BAD) begin
      stb.raiseInt = 1'b1;
      stb.cmdErr   = 1'b1;
    end
    if (finish) begin
      stb.raiseInt = 1'b1;
      stb.doneKind = pendHot;
      if (opFail) begin
        stb.cmdErr   = 1'b1;
        stb.failKind = pendHot;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ      <= CLS_NONE;
      execStrobe <= 1'b0;
      opClass    <= CLS_NONE;
    end else begin
      execStrobe <= armArray;
      opClass    <= armArray ? armCode : CLS_NONE;
      if (stb.warmRst)   pendQ <= CLS_NONE;
      else if (armArray) pendQ <= armCode;
      else if (finish)   pendQ <= CLS_NONE;
    end
  end

endmodule

// File: rtl/flash_csr_regs.sv
module flash_csr_regs
  import flash_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [REG_W-1:0] wrData,
  input  ctrlStrobe_t      stb,
  output logic [REG_W-1:0] rdData,
  output logic             intBusy,
  output logic             intPin,
  output logic             readyPin
);

  localparam int KINDS = 3;

  logic [REG_W-1:0] cmdQ, cfg1Q, cfg2Q, statQ, intQ;
  logic [REG_W-1:0] intNext, statNext;
  logic [REG_W-1:0] intSet, statSet;
  logic             intWr;

  assign intWr   = wrEn && (regSel == SEL_INT);
  assign intBusy = intQ[INT_ANY];

  // place the one-hot kind strobes onto their register bit positions
  always_comb begin
    intSet  = '0;
    statSet = '0;
    intSet[INT_ANY]  = stb.raiseInt;
    statSet[ERR_CMD] = stb.cmdErr;
    for (int i = 0; i < KINDS; i++) begin
      intSet[INT_DONE0 + i]  = stb.doneKind[i];
      statSet[ERR_KIND0 + i] = stb.failKind[i];
    end
  end

  always_comb begin
    intNext  = intQ;
    statNext = statQ;
    if (intWr) begin
      intNext = intQ & wrData;
      if (!intNext[INT_ANY]) statNext[ERR_KIND0+KINDS-1:ERR_CMD] = '0;
    end
    intNext  = intNext | intSet;
    statNext = statNext | statSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= '0;
      cfg1Q    <= CFG1_RST;
      cfg2Q    <= CFG2_RST;
      statQ    <= '0;
      intQ     <= INT_COLD;
      readyPin <= 1'b1;
      intPin   <= INT_COLD[INT_ANY] ^ ~CFG1_RST[CFG1_POL];
    end else begin
      intPin <= intQ[INT_ANY] ^ ~cfg1Q[CFG1_POL];
      if (stb.warmRst) begin
        cmdQ     <= '0;
        cfg1Q    <= CFG1_RST;
        cfg2Q    <= CFG2_RST;
        statQ    <= '0;
        intQ     <= INT_WARM;
        readyPin <= 1'b1;
      end else begin
        intQ  <= intNext;
        statQ <= statNext;
        if (stb.cmdTake) cmdQ <= wrData;
        if (wrEn && regSel == SEL_CFG1) begin
          cfg1Q    <= wrData;
          readyPin <= wrData[CFG1_RDY];
        end
        if (wrEn && regSel == SEL_CFG2) cfg2Q <= wrData;
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_CMD:  rdData = cmdQ;
      SEL_CFG1: rdData = cfg1Q & CFG1_RD_MASK;
      SEL_CFG2: rdData = cfg2Q;
      SEL_STAT: rdData = statQ;
      SEL_INT:  rdData = intQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/flash_csr_unit.sv
module flash_csr_unit
  import flash_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             opDone,
  input  logic             opFail,
  output logic             execStrobe,
  output logic [CLS_W-1:0] opClass,
  output logic             intPin,
  output logic             readyPin
);

  ctrlStrobe_t stb;
  logic        intBusy;
  logic        cmdWr;

  assign cmdWr = wrEn && (regSel == SEL_CMD);

  flash_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .wrData(wrData),
    .intBusy(intBusy), .opDone(opDone), .opFail(opFail),
    .stb(stb), .execStrobe(execStrobe), .opClass(opClass)
  );

  flash_csr_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .stb(stb), .rdData(rdData), .intBusy(intBusy),
    .intPin(intPin), .readyPin(readyPin)
  );

endmodule

// File: rtl/flash_csr_chk.sv
module flash_csr_chk
  import flash_csr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [SEL_W-1:0] regSel,
  input logic [REG_W-1:0] wrData,
  input logic             intBusy,
  input ctrlStrobe_t      stb,
  input logic             execStrobe,
  input logic [CLS_W-1:0] opClass,
  input logic             readyPin
);

  // R3
  cmd_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CMD && intBusy) |=> !execStrobe);

  // R5
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CFG1) |=> (readyPin == $past(wrData[CFG1_RDY])));

  // R6
  strobe_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    execStrobe |-> (opClass != 2'd0));

  // R7
  raise_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.raiseInt |=> intBusy);

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_INT && !wrData[INT_ANY] && !stb.raiseInt) |=> !intBusy);

  // R11
  warm_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.warmRst |=> (intBusy && readyPin));

endmodule

bind flash_csr_unit flash_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
  .intBusy(intBusy), .stb(stb), .execStrobe(execStrobe), .opClass(opClass),
  .readyPin(readyPin)
);

// File: tb/tb_flash_csr_unit.sv
`timescale 1ns/1ps
module tb_flash_csr_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [15:0] wrData = 16'h0;
  logic        opDone = 1'b0;
  logic        opFail = 1'b0;
  logic [15:0] rdData;
  logic        execStrobe;
  logic [1:0]  opClass;
  logic        intPin, readyPin;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_csr_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .opDone(opDone), .opFail(opFail),
    .execStrobe(execStrobe), .opClass(opClass),
    .intPin(intPin), .readyPin(readyPin)
  );

  // ---------------- reference model ----------------
  logic [15:0] mCmd, mCfg1, mCfg2, mSt, mInt;
  logic        mReady, mIntPin, mExec;
  int          mPend, mClass;

  function automatic int kindOf(input logic [15:0] v);
    if (v == 16'h0000 || v == 16'h0013) return 1;
    if (v == 16'h0080 || v == 16'h001a || v == 16'h001b) return 2;
    if (v == 16'h0094 || v == 16'h0095 || v == 16'h0030) return 3;
    if (v == 16'h0023 || v == 16'h0027 || v == 16'h002a || v == 16'h002c ||
        v == 16'h0071 || v == 16'h0065) return 4;
    if (v == 16'h00b0) return 5;
    if (v == 16'h00f0 || v == 16'h00f3) return 6;
    return 7;
  endfunction

  function automatic logic [15:0] modelRead(input logic [2:0] s);
    case (s)
      3'd0: return mCmd;
      3'd1: return mCfg1 & 16'hffe0;
      3'd2: return mCfg2;
      3'd3: return mSt;
      3'd4: return mInt;
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelCold();
    mCmd = 0; mCfg1 = 16'h40c0; mCfg2 = 0; mSt = 0; mInt = 16'h8080;
    mReady = 1; mIntPin = 1; mExec = 0; mClass = 0; mPend = 0;
  endtask

  initial modelCold();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelCold();
    else begin
      logic [15:0] nInt, nSt, oInt, oCfg1;
      int k, oPend;
      bit acc, fin;
      oInt = mInt; oCfg1 = mCfg1; oPend = mPend;
      mIntPin = oInt[15] ^ ~oCfg1[6];
      acc = wrEn && regSel == 3'd0 && !oInt[15];
      k = kindOf(wrData);
      fin = opDone && oPend != 0;
      mExec = 0; mClass = 0;
      if (acc && k == 6) begin
        mCmd = 0; mCfg1 = 16'h40c0; mCfg2 = 0; mSt = 0; mInt = 16'h8010;
        mReady = 1; mPend = 0;
      end else begin
        nInt = mInt; nSt = mSt;
        if (wrEn && regSel == 3'd1) begin mCfg1 = wrData; mReady = wrData[7]; end
        if (wrEn && regSel == 3'd2) mCfg2 = wrData;
        if (wrEn && regSel == 3'd4) begin
          nInt = nInt & wrData;
          if (!nInt[15]) nSt = nSt & ~16'h3c00;
        end
        if (acc) begin
          mCmd = wrData;
          if (k >= 1 && k <= 3) begin mExec = 1; mClass = k; end
          if (k == 4) nInt = nInt | 16'h8000;
          if (k == 7) begin nInt = nInt | 16'h8000; nSt = nSt | 16'h0400; end
        end
        if (fin) begin
          nInt = nInt | 16'h8000 | (oPend == 1 ? 16'h0080 : oPend == 2 ? 16'h0040 : 16'h0020);
          if (opFail)
            nSt = nSt | 16'h0400 | (oPend == 1 ? 16'h2000 : oPend == 2 ? 16'h1000 : 16'h0800);
        end
        if (acc && k >= 1 && k <= 3) mPend = k;
        else if (fin) mPend = 0;
        mInt = nInt; mSt = nSt;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      string rt;
      case (regSel)
        3'd0: rt = "R6 cmd read";
        3'd1: rt = "R2 cfg1 read";
        3'd2: rt = "R2 cfg2 read";
        3'd3: rt = "R8 status read";
        3'd4: rt = "R7 int read";
        default: rt = "R2 unmapped read";
      endcase
      check(rt, rdData, modelRead(regSel));
      check("R4 intPin", {15'h0, intPin}, {15'h0, mIntPin});
      check("R5 readyPin", {15'h0, readyPin}, {15'h0, mReady});
      check("R6 execStrobe", {15'h0, execStrobe}, {15'h0, mExec});
      check("R6 opClass", {14'h0, opClass}, mClass[15:0]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1; regSel = s; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic done(input bit f);
    @(negedge clk);
    opDone = 1; opFail = f;
    @(negedge clk);
    opDone = 0; opFail = 0;
  endtask

  task automatic expectReg(input string tag, input logic [2:0] s, input logic [15:0] e);
    @(negedge clk);
    regSel = s;
    #1;
    check(tag, rdData, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1;
    // R1 cold reset values
    expectReg("R1 cfg1", 3'd1, 16'h40c0);
    expectReg("R1 cfg2", 3'd2, 16'h0000);
    expectReg("R1 status", 3'd3, 16'h0000);
    expectReg("R1 int", 3'd4, 16'h8080);
    expectReg("R1 cmd", 3'd0, 16'h0000);
    check("R1 ready", {15'h0, readyPin}, 16'h1);
    check("R1 intPin", {15'h0, intPin}, 16'h1);

    // R3 refused while bit 15 set
    wr(3'd0, 16'h0094);
    expectReg("R3 cmd kept", 3'd0, 16'h0000);

    // R2 / R5 / R4 configuration
    wr(3'd1, 16'hffff);
    expectReg("R2 cfg1 mask", 3'd1, 16'hffe0);
    wr(3'd1, 16'h4000);
    check("R5 ready low", {15'h0, readyPin}, 16'h0);
    idle(1);
    check("R4 polarity", {15'h0, intPin}, 16'h0);
    wr(3'd2, 16'h1234);
    expectReg("R2 cfg2", 3'd2, 16'h1234);
    wr(3'd3, 16'hffff);
    expectReg("R2 status ro", 3'd3, 16'h0000);
    wr(3'd5, 16'hffff);
    expectReg("R2 unmapped", 3'd5, 16'h0000);
    wr(3'd1, 16'h40c0);

    // R10 acknowledge
    wr(3'd4, 16'h0000);
    expectReg("R10 int cleared", 3'd4, 16'h0000);

    // R6 R7 load
    wr(3'd0, 16'h0013);
    idle(2);
    done(0);
    expectReg("R7 load done", 3'd4, 16'h8080);
    wr(3'd4, 16'h0000);

    // R8 program fail, R10 partial ack
    wr(3'd0, 16'h001a);
    done(1);
    expectReg("R8 prog fail status", 3'd3, 16'h1400);
    expectReg("R7 prog int", 3'd4, 16'h8040);
    wr(3'd4, 16'h7fff);
    expectReg("R10 partial and", 3'd4, 16'h0040);
    expectReg("R10 errors cleared", 3'd3, 16'h0000);
    wr(3'd4, 16'h0000);

    // R8 erase fail; ack keeping bit 15 keeps errors
    wr(3'd0, 16'h0095);
    done(1);
    wr(3'd4, 16'hffff);
    expectReg("R8 erase fail kept", 3'd3, 16'h0c00);
    expectReg("R7 erase int", 3'd4, 16'h8020);
    wr(3'd4, 16'h0000);

    // R9 immediate, suspend, unknown
    wr(3'd0, 16'h002c);
    expectReg("R9 lock", 3'd4, 16'h8000);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h00b0);
    expectReg("R9 suspend", 3'd4, 16'h0000);
    expectReg("R9 suspend cmd", 3'd0, 16'h00b0);
    wr(3'd0, 16'h0155);
    expectReg("R9 unknown status", 3'd3, 16'h0400);
    expectReg("R9 unknown int", 3'd4, 16'h8000);
    wr(3'd4, 16'h0000);

    // R7 done with nothing pending
    done(0);
    expectReg("R7 spurious done", 3'd4, 16'h0000);

    // R11 warm reset drops pending resume
    wr(3'd2, 16'h00aa);
    wr(3'd0, 16'h0030);
    wr(3'd0, 16'h00f3);
    expectReg("R11 int", 3'd4, 16'h8010);
    expectReg("R11 cfg2", 3'd2, 16'h0000);
    expectReg("R11 cmd", 3'd0, 16'h0000);
    done(0);
    expectReg("R11 pending dropped", 3'd4, 16'h8010);

    // R12 same-cycle ack and completion
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0000);
    @(negedge clk);
    wrEn = 1; regSel = 3'd4; wrData = 16'h0000; opDone = 1; opFail = 0;
    @(negedge clk);
    wrEn = 0; opDone = 0;
    expectReg("R12 order", 3'd4, 16'h8080);

    // R11 other reset opcode
    wr(3'd4, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h00f0);
    expectReg("R11 f0 cfg1", 3'd1, 16'h40c0);
    check("R5 ready after warm", {15'h0, readyPin}, 16'h1);

    idle(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule